// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a small cache placed between a processor's load/store port and a slower main memory that is addressed by 32-bit word. It keeps four lines, each holding two aligned 32-bit words, together with a valid flag and an address tag per line. A single tag comparison against the line picked by the address decides whether an access hits.

Loads that hit are answered from the cache one cycle after the request is accepted, without any memory traffic. Loads that miss fetch both words of the line from memory, install the line under the new tag and then return the requested word. Every store is written through to memory. A store that misses also allocates the line: the line is fetched first, the stored word is merged into it, and the memory write follows.

The processor side uses a request/ready pair in which ready is a one-cycle completion pulse. The memory side uses a request that is held, with stable address and data, until memory answers with ready.

Top module: `dm_wt_cache`

## Requirements
- R1: A byte address is split as: bits [2:0] byte within the line, bit [2] also choosing the word (0 = lower address), bits [4:3] the line index, bits [31:5] the tag; memory word addresses are the byte address shifted right by two.
- R2: After reset every line is invalid, cpu_ready and mem_req are low, and the first access to any address is a miss.
- R3: A load that hits raises cpu_ready exactly one cycle after acceptance with the cached word and issues no memory request.
- R4: A load that misses reads both words of its line from memory, lower word first, installs the line under the new tag, and raises cpu_ready only after the last read handshake, returning the requested word.
- R5: A store that hits updates the cached word, raises cpu_ready one cycle after acceptance, and writes the same word to the same word address in memory.
- R6: A store that misses fetches both words of the line, merges the stored word, installs the line, raises cpu_ready after the fill, and then writes the word to memory; the other word of the line keeps the memory value.
- R7: Two addresses with equal index and different tags collide: the newer replaces the older, so a later access to the older one misses.
- R8: While a line fill or a memory write is in progress, no new request is accepted, and mem_req, mem_we and mem_addr stay unchanged until mem_ready is seen.
- R9: A request is accepted when cpu_req is high, the block is idle and cpu_ready is low; each accepted request produces exactly one single-cycle cpu_ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load result, valid with cpu_ready |
| mem_req | output | 1 | Memory request, held until mem_ready |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory handshake completion |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |

## Verification
The case of interest is a store whose write-through to memory is still draining when the next processor request arrives, so that the drain and a new lookup compete for the same cycle. The bench provokes it by fixing the memory latency at several cycles and raising a load right after the store's completion pulse, and also lets it arise at random in the mixed sequence. It is judged by confirming that the memory write was counted by the memory model before the new request's ready pulse, and that the load still returns the value computed from the bench's own reference array.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  // Controller states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } dmc_state_e;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 4,
  parameter int TAG_W = 27
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(LINES)-1:0] lk_idx,
  input  logic [TAG_W-1:0]         lk_tag,
  output logic                     lk_hit,
  input  logic                     wr_en,
  input  logic [$clog2(LINES)-1:0] wr_idx,
  input  logic [TAG_W-1:0]         wr_tag
);
  localparam int IDX_W = $clog2(LINES);

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= wr_tag;
      end
    end
  end

  // the single comparator
  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  AST_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (valid_q == '0)); // R2

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int LINES  = 4,
  parameter int WORDS  = 2,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic [$clog2(LINES)-1:0] rd_idx,
  input  logic [$clog2(WORDS)-1:0] rd_word,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     wr_en,
  input  logic [$clog2(LINES)-1:0] wr_idx,
  input  logic [$clog2(WORDS)-1:0] wr_word,
  input  logic [DATA_W-1:0]        wr_data
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int WSEL_W = $clog2(WORDS);

  logic [DATA_W-1:0] word_q [LINES][WORDS];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (wr_en && wr_idx == IDX_W'(l) && wr_word == WSEL_W'(w))
          word_q[l][w] <= wr_data;
      end
    end
  end

  assign rd_data = word_q[rd_idx][rd_word];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 4,
  parameter int WORDS  = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  // processor side
  input  logic                              cpu_req,
  input  logic                              cpu_we,
  input  logic [ADDR_W-1:0]                 cpu_addr,
  input  logic [DATA_W-1:0]                 cpu_wdata,
  output logic                              cpu_ready,
  output logic [DATA_W-1:0]                 cpu_rdata,
  // lookup to the arrays
  output logic [$clog2(LINES)-1:0]          lk_idx,
  output logic [ADDR_W-$clog2(DATA_W/8)-$clog2(WORDS)-$clog2(LINES)-1:0] lk_tag,
  output logic [$clog2(WORDS)-1:0]          lk_word,
  input  logic                              lk_hit,
  input  logic [DATA_W-1:0]                 lk_data,
  // array updates
  output logic                              tag_we,
  output logic [$clog2(LINES)-1:0]          tag_idx,
  output logic [ADDR_W-$clog2(DATA_W/8)-$clog2(WORDS)-$clog2(LINES)-1:0] tag_val,
  output logic                              dat_we,
  output logic [$clog2(LINES)-1:0]          dat_idx,
  output logic [$clog2(WORDS)-1:0]          dat_word,
  output logic [DATA_W-1:0]                 dat_val,
  // memory side
  output logic                              mem_req,
  output logic                              mem_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
  output logic [DATA_W-1:0]                 mem_wdata,
  input  logic                              mem_ready,
  input  logic [DATA_W-1:0]                 mem_rdata
);
  localparam int BYTE_W  = $clog2(DATA_W/8);
  localparam int WSEL_W  = $clog2(WORDS);
  localparam int IDX_W   = $clog2(LINES);
  localparam int OFF_W   = BYTE_W + WSEL_W;
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int MADDR_W = ADDR_W - BYTE_W;

  // ---- address arithmetic ----
  function automatic logic [IDX_W-1:0] f_index(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [WSEL_W-1:0] f_word(input logic [ADDR_W-1:0] a);
    return a[BYTE_W +: WSEL_W];
  endfunction

  function automatic logic [MADDR_W-1:0] f_fill_addr(input logic [TAG_W-1:0] t,
                                                     input logic [IDX_W-1:0] i,
                                                     input logic [WSEL_W-1:0] w);
    return {t, i, w};
  endfunction

  // ---- state ----
  dmc_state_e         state_q, state_d;
  logic [MADDR_W-1:0] r_waddr;
  logic               r_we;
  logic [DATA_W-1:0]  r_wdata;
  logic [WSEL_W-1:0]  beat_q;
  logic               ready_q;
  logic [DATA_W-1:0]  rdata_q;

  logic [IDX_W-1:0]   r_idx;
  logic [TAG_W-1:0]   r_tag;
  logic [WSEL_W-1:0]  r_word;
  logic               addr_lsb_unused;

  assign r_idx  = r_waddr[WSEL_W +: IDX_W];
  assign r_tag  = r_waddr[MADDR_W-1 -: TAG_W];
  assign r_word = r_waddr[WSEL_W-1:0];
  assign addr_lsb_unused = ^cpu_addr[BYTE_W-1:0];

  // ---- named events ----
  logic accept_ev;
  logic rd_hit_ev;
  logic wr_hit_ev;
  logic miss_ev;
  logic beat_ev;
  logic fill_last_ev;
  logic wr_done_ev;
  logic [DATA_W-1:0] fill_word;

  assign lk_idx  = f_index(cpu_addr);
  assign lk_tag  = f_tag(cpu_addr);
  assign lk_word = f_word(cpu_addr);

  assign accept_ev    = (state_q == ST_IDLE) && cpu_req && !ready_q;
  assign rd_hit_ev    = accept_ev && !cpu_we && lk_hit;
  assign wr_hit_ev    = accept_ev && cpu_we && lk_hit;
  assign miss_ev      = accept_ev && !lk_hit;
  assign beat_ev      = (state_q == ST_FILL) && mem_ready;
  assign fill_last_ev = beat_ev && (beat_q == WSEL_W'(WORDS-1));
  assign wr_done_ev   = (state_q == ST_WRITE) && mem_ready;

  // merge of the stored word into the arriving line
  assign fill_word = (r_we && beat_q == r_word) ? r_wdata : mem_rdata;

  // ---- next state ----
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (miss_ev)        state_d = ST_FILL;
        else if (wr_hit_ev) state_d = ST_WRITE;
      end
      ST_FILL: begin
        if (fill_last_ev)   state_d = r_we ? ST_WRITE : ST_IDLE;
      end
      ST_WRITE: begin
        if (wr_done_ev)     state_d = ST_IDLE;
      end
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      r_waddr <= '0;
      r_we    <= 1'b0;
      r_wdata <= '0;
      beat_q  <= '0;
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      ready_q <= rd_hit_ev | wr_hit_ev | fill_last_ev;
      if (accept_ev) begin
        r_waddr <= cpu_addr[ADDR_W-1:BYTE_W];
        r_we    <= cpu_we;
        r_wdata <= cpu_wdata;
        beat_q  <= '0;
      end
      if (beat_ev)
        beat_q <= beat_q + 1'b1;
      if (rd_hit_ev)
        rdata_q <= lk_data;
      else if (wr_hit_ev)
        rdata_q <= cpu_wdata;
      else if (beat_ev && beat_q == r_word)
        rdata_q <= fill_word;
    end
  end

  // ---- array updates ----
  always_comb begin
    dat_we   = 1'b0;
    dat_idx  = r_idx;
    dat_word = beat_q;
    dat_val  = fill_word;
    if (wr_hit_ev) begin
      dat_we   = 1'b1;
      dat_idx  = lk_idx;
      dat_word = lk_word;
      dat_val  = cpu_wdata;
    end else if (beat_ev) begin
      dat_we   = 1'b1;
    end
  end

  assign tag_we  = fill_last_ev;
  assign tag_idx = r_idx;
  assign tag_val = r_tag;

  // ---- memory side ----
  assign mem_req   = (state_q == ST_FILL) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = (state_q == ST_FILL) ? f_fill_addr(r_tag, r_idx, beat_q) : r_waddr;
  assign mem_wdata = r_wdata;

  assign cpu_ready = ready_q;
  assign cpu_rdata = rdata_q;

  // ---- assertions ----
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready); // R9

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R8

  AST_HIT_SILENT: assert property (@(posedge clk) disable iff (rst)
    rd_hit_ev |=> (cpu_ready && !mem_req)); // R3

  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (rst)
    wr_hit_ev |=> (cpu_ready && mem_req && mem_we)); // R5

  AST_FILL_GATES_READY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FILL && !fill_last_ev) |=> !cpu_ready); // R4

  AST_MISS_STARTS_READ: assert property (@(posedge clk) disable iff (rst)
    miss_ev |=> (mem_req && !mem_we && !cpu_ready)); // R6

endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 4,
  parameter int WORDS  = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cpu_req,
  input  logic                               cpu_we,
  input  logic [ADDR_W-1:0]                  cpu_addr,
  input  logic [DATA_W-1:0]                  cpu_wdata,
  output logic                               cpu_ready,
  output logic [DATA_W-1:0]                  cpu_rdata,
  output logic                               mem_req,
  output logic                               mem_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
  output logic [DATA_W-1:0]                  mem_wdata,
  input  logic                               mem_ready,
  input  logic [DATA_W-1:0]                  mem_rdata
);
  localparam int BYTE_W = $clog2(DATA_W/8);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - BYTE_W - WSEL_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic [WSEL_W-1:0] lk_word;
  logic              lk_hit;
  logic [DATA_W-1:0] lk_data;
  logic              tag_we;
  logic [IDX_W-1:0]  tag_idx;
  logic [TAG_W-1:0]  tag_val;
  logic              dat_we;
  logic [IDX_W-1:0]  dat_idx;
  logic [WSEL_W-1:0] dat_word;
  logic [DATA_W-1:0] dat_val;

  dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst    (rst),
    .lk_idx (lk_idx),
    .lk_tag (lk_tag),
    .lk_hit (lk_hit),
    .wr_en  (tag_we),
    .wr_idx (tag_idx),
    .wr_tag (tag_val)
  );

  dmc_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rd_idx  (lk_idx),
    .rd_word (lk_word),
    .rd_data (lk_data),
    .wr_en   (dat_we),
    .wr_idx  (dat_idx),
    .wr_word (dat_word),
    .wr_data (dat_val)
  );

  dmc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_ready (cpu_ready),
    .cpu_rdata (cpu_rdata),
    .lk_idx    (lk_idx),
    .lk_tag    (lk_tag),
    .lk_word   (lk_word),
    .lk_hit    (lk_hit),
    .lk_data   (lk_data),
    .tag_we    (tag_we),
    .tag_idx   (tag_idx),
    .tag_val   (tag_val),
    .dat_we    (dat_we),
    .dat_idx   (dat_idx),
    .dat_word  (dat_word),
    .dat_val   (dat_val),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata)
  );

endmodule

// File: tb/dm_wt_cache_tb.sv
module dm_wt_cache_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req;
  logic        mem_we;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dm_wt_cache u_dut (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  // ---- memory model and bench reference ----
  logic [31:0] bmem [64];
  logic [31:0] refm [64];
  int n_rd = 0;
  int n_wr = 0;
  logic [29:0] rd_prev = '0;
  logic [29:0] rd_last = '0;
  int wait_cnt = 0;
  int cur_lat = 0;
  int fixed_lat = -1;

  always @(negedge clk) begin
    if (rst) begin
      mem_ready = 1'b0;
      wait_cnt = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt >= cur_lat) begin
        mem_ready = 1'b1;
        wait_cnt = 0;
        if (mem_we) begin
          bmem[mem_addr[5:0]] = mem_wdata;
          n_wr++;
        end else begin
          mem_rdata = bmem[mem_addr[5:0]];
          rd_prev = rd_last;
          rd_last = mem_addr;
          n_rd++;
        end
        cur_lat = (fixed_lat >= 0) ? fixed_lat : int'($urandom_range(2, 0));
      end else begin
        wait_cnt++;
      end
    end
  end

  // bench view of the cache contents (R1 address split)
  bit        bvalid [4];
  logic [26:0] btag [4];

  function automatic int b_idx(input logic [31:0] a);
    return int'((a / 8) % 4);
  endfunction
  function automatic logic [26:0] b_tag(input logic [31:0] a);
    return 27'(a / 32);
  endfunction
  function automatic int b_wordno(input logic [31:0] a);
    return int'((a / 4) % 64);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd, input bit drain);
    bit hit_exp;
    bit busy0;
    int rd0, wr0, cyc, base;
    hit_exp = bvalid[b_idx(a)] && (btag[b_idx(a)] == b_tag(a));
    rd0 = n_rd;
    wr0 = n_wr;
    busy0 = mem_req;
    cpu_req = 1'b1;
    cpu_we = we;
    cpu_addr = a;
    cpu_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 200);
    cpu_req = 1'b0;
    chk(cpu_ready, "R9 ready seen", 32'(cpu_ready), 32'd1);
    if (busy0)
      chk(n_wr > wr0, "R8 pending write drains first", 32'(n_wr - wr0), 32'd1);
    if (hit_exp) begin
      chk(n_rd == rd0, "R3/R5 hit has no memory read", 32'(n_rd - rd0), 32'd0);
      if (!busy0)
        chk(cyc == 1, "R3/R5 hit latency", 32'(cyc), 32'd1);
    end else begin
      base = b_wordno(a) & ~1;
      chk(n_rd - rd0 == 2, "R4/R6 miss reads two words", 32'(n_rd - rd0), 32'd2);
      chk(rd_prev == 30'(base) && rd_last == 30'(base + 1), "R4 fill order",
          {rd_prev[15:0], rd_last[15:0]}, {16'(base), 16'(base + 1)});
    end
    if (we) begin
      refm[b_wordno(a)] = wd;
    end else begin
      chk(cpu_rdata == refm[b_wordno(a)], "R3/R4 load data", cpu_rdata, refm[b_wordno(a)]);
    end
    bvalid[b_idx(a)] = 1'b1;
    btag[b_idx(a)] = b_tag(a);
    @(negedge clk);
    chk(!cpu_ready, "R9 single pulse", 32'(cpu_ready), 32'd0);
    if (drain) begin
      cyc = 0;
      while (mem_req && cyc < 50) begin
        @(negedge clk);
        cyc++;
      end
      if (we)
        chk(bmem[b_wordno(a)] == wd, "R5/R6 memory written", bmem[b_wordno(a)], wd);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) begin
      bmem[i] = 32'hC0DE0000 + 32'(i * 17);
      refm[i] = bmem[i];
    end
    for (int i = 0; i < 4; i++) begin
      bvalid[i] = 1'b0;
      btag[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cpu_ready, "R2 ready low after reset", 32'(cpu_ready), 32'd0);
    chk(!mem_req, "R2 mem_req low after reset", 32'(mem_req), 32'd0);

    // R2/R4 first read misses; R1 other word of line hits
    access(1'b0, 32'h08, 32'h0, 1'b1);
    access(1'b0, 32'h0C, 32'h0, 1'b1);
    // R7 collision on index 1: 0x28 replaces 0x08
    access(1'b0, 32'h28, 32'h0, 1'b1);
    access(1'b0, 32'h08, 32'h0, 1'b1);
    // R5 write hit then read back
    access(1'b1, 32'h08, 32'h1234_5678, 1'b1);
    access(1'b0, 32'h08, 32'h0, 1'b1);
    // R6 write miss on index 2, other word keeps memory value
    access(1'b1, 32'h34, 32'hBEEF_0001, 1'b1);
    access(1'b0, 32'h30, 32'h0, 1'b1);
    access(1'b0, 32'h34, 32'h0, 1'b1);
    // R8 store drain overlapping the next request
    fixed_lat = 3;
    cur_lat = 3;
    access(1'b1, 32'h34, 32'hBEEF_0002, 1'b0);
    chk(mem_req && mem_we, "R8 write still pending", 32'(mem_req), 32'd1);
    access(1'b0, 32'h30, 32'h0, 1'b1);
    access(1'b0, 32'h34, 32'h0, 1'b1);
    fixed_lat = -1;

    // random mix over a small, collision-heavy range
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      a = 32'($urandom_range(63, 0)) * 4;
      access(1'($urandom_range(1, 0)), a, $urandom, 1'($urandom_range(1, 0)));
    end
    repeat (10) @(negedge clk);
    for (int i = 0; i < 64; i++)
      chk(bmem[i] == refm[i], "R5 memory matches reference", bmem[i], refm[i]);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule